// File: doc/BRIEF.md
# Refresh Scheduler with Deferred Refresh Credit

This block sits on the controller side of a four-bank DDR SDRAM interface and decides when auto-refresh commands go out. A free-running interval timer adds one refresh to an owed count at every interval, for example every 1040 cycles at 133 MHz, which gives a 7.8 µs average period. Refresh is only legal when every bank is precharged. While few refreshes are owed, the block waits for the command arbiter to report that all banks are idle and then asks for a refresh without disturbing traffic. Once the owed count reaches the urgency level, it also asks the arbiter to close all banks with a precharge-all command.

Up to eight refreshes can be owed, and the backlog drains as a burst of refreshes issued one after another. After each granted refresh a lockout of the refresh row cycle time blocks further commands. After an exit from self refresh, a separate blocking window of configurable length holds off commands and refresh requests. The arbiter sees three things: a refresh request it grants with a single-cycle handshake, a busy flag telling it to issue no other commands, and an urgent flag.

Top module: `refresh_sched`

## Requirements
- R1: After reset, owed_o is 0 and ref_req_o, pre_all_req_o, busy_o and urgent_o are all low.
- R2: The owed count (owed_o, plain binary) rises by one at the end of every TICK_CYCLES-th clock cycle after reset is released. The first rise comes after exactly TICK_CYCLES cycles.
- R3: The owed count never exceeds MAX_OWED. An interval that ends while the count is already MAX_OWED and no refresh is granted adds nothing.
- R4: ref_req_o is high whenever no lockout or exit window is running, the owed count is non-zero, banks_idle_i is high and sr_exit_i is low. It stays high, and the owed count does not change, until ref_gnt_i is sampled high together with it.
- R5: Each clock edge that samples ref_req_o and ref_gnt_i both high lowers the owed count by one, unless an interval ends at that same edge.
- R6: urgent_o is high exactly when the owed count is URGENT_AT or more.
- R7: pre_all_req_o is high only while urgent_o is high, banks_idle_i is low and no window is running. When the count is below URGENT_AT, no precharge-all is ever requested.
- R8: After an accepted refresh, busy_o is high and ref_req_o is low for exactly TRFC_CYCLES cycles. The next refresh can therefore be granted no earlier than TRFC_CYCLES+1 cycles after the previous one.
- R9: With banks idle and the grant held high, a backlog of MAX_OWED refreshes drains as a burst of MAX_OWED grants spaced exactly TRFC_CYCLES+1 cycles apart, leaving the owed count at 0.
- R10: A clock edge that samples sr_exit_i high starts a window of TXS_CYCLES cycles during which busy_o is high and ref_req_o is low. ref_req_o is also low in the cycle where sr_exit_i is high. The owed count is kept.
- R11: busy_o is high whenever urgent_o is high, even if no window is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| banks_idle_i | input | 1 | All four banks are precharged |
| sr_exit_i | input | 1 | Pulse marking exit from self refresh |
| ref_gnt_i | input | 1 | Arbiter accepts the refresh command this cycle |
| ref_req_o | output | 1 | Refresh command request |
| pre_all_req_o | output | 1 | Request to close all banks with one precharge |
| busy_o | output | 1 | Arbiter must issue no other command |
| urgent_o | output | 1 | Refresh backlog has reached the urgency level |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes currently owed |

## Verification
The owed count is driven in several ways. Banks are held busy across many intervals to watch it climb, cross the urgency level and saturate. A single credit is granted late to separate a pending request from an accepted one. The full backlog is drained with the grant tied high, so any error in burst spacing or lockout length shows up as a wrong gap between grants. A self-refresh exit pulse arrives while a request is pending, which separates the exit window from the shorter refresh lockout. The same stimulus with banks idle and with banks busy shows whether opportunistic refresh and forced precharge-all are kept apart.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    // Phase of the command-blocking window shared by refresh lockout and
    // self-refresh exit.
    typedef enum logic [1:0] {
        PH_READY = 2'd0,
        PH_LOCK  = 2'd1,
        PH_SRX   = 2'd2
    } phase_e;

    // Outputs presented to the command arbiter.
    typedef struct packed {
        logic ref_req;
        logic pre_all;
        logic busy;
    } arb_ctl_t;

    // Counter width able to hold values 0 .. n-1 (at least one bit).
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int unsigned TICK_CYCLES = 1040
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    import rfsh_pkg::*;

    localparam int unsigned TW = cnt_w(TICK_CYCLES);

    generate
        if (TICK_CYCLES < 2) begin : g_every
            // Degenerate interval: one refresh owed per cycle.
            logic live_q;
            always_ff @(posedge clk) begin
                if (rst) live_q <= 1'b0;
                else     live_q <= 1'b1;
            end
            assign tick_o = live_q;
        end else begin : g_count
            localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);
            logic [TW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)               cnt_q <= '0;
                else if (cnt_q == LAST) cnt_q <= '0;
                else                    cnt_q <= cnt_q + 1'b1;
            end
            assign tick_o = (cnt_q == LAST);

            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/rfsh_owed_counter.sv
module rfsh_owed_counter #(
    parameter int unsigned MAX_OWED  = 8,
    parameter int unsigned URGENT_AT = 7
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            tick_i,
    input  logic                            take_i,
    output logic [$clog2(MAX_OWED+1)-1:0]   owed_o,
    output logic                            urgent_o
);
    localparam int unsigned OW = $clog2(MAX_OWED + 1);
    localparam logic [OW-1:0] CAP = OW'(MAX_OWED);
    localparam logic [OW-1:0] URG = OW'(URGENT_AT);

    logic [OW-1:0] owed_q;
    logic [OW-1:0] owed_d;

    always_comb begin
        owed_d = owed_q;
        unique case ({tick_i, take_i})
            2'b10: if (owed_q != CAP)  owed_d = owed_q + 1'b1;
            2'b01: if (owed_q != '0)   owed_d = owed_q - 1'b1;
            default: owed_d = owed_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owed_q <= '0;
        else     owed_q <= owed_d;
    end

    assign owed_o   = owed_q;
    assign urgent_o = (owed_q >= URG);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        owed_q <= CAP);

    // R2
    tick_adds_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !take_i && owed_q != CAP) |=> (owed_q == $past(owed_q) + 1'b1));

    // R5
    take_subtracts_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && !tick_i) |=> (owed_q == $past(owed_q) - 1'b1));

endmodule

// File: rtl/rfsh_lockout.sv
module rfsh_lockout #(
    parameter int unsigned TRFC_CYCLES = 10,
    parameter int unsigned TXS_CYCLES  = 200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_rfc_i,
    input  logic              start_srx_i,
    output rfsh_pkg::phase_e  phase_o
);
    import rfsh_pkg::*;

    localparam int unsigned LONGEST = max2(max2(TRFC_CYCLES, TXS_CYCLES), 2);
    localparam int unsigned CW      = cnt_w(LONGEST);
    localparam logic [CW-1:0] RFC_LOAD = CW'(TRFC_CYCLES - 1);
    localparam logic [CW-1:0] SRX_LOAD = CW'(TXS_CYCLES - 1);

    phase_e        phase_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_READY;
            left_q  <= '0;
        end else if (start_srx_i) begin
            phase_q <= PH_SRX;
            left_q  <= SRX_LOAD;
        end else if (start_rfc_i) begin
            phase_q <= PH_LOCK;
            left_q  <= RFC_LOAD;
        end else if (phase_q != PH_READY) begin
            if (left_q == '0) phase_q <= PH_READY;
            else              left_q  <= left_q - 1'b1;
        end
    end

    assign phase_o = phase_q;

    // R8
    rfc_enters_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (start_rfc_i && !start_srx_i) |=> (phase_q == PH_LOCK));

    // R10
    srx_enters_window_chk: assert property (@(posedge clk) disable iff (rst)
        start_srx_i |=> (phase_q == PH_SRX && left_q == SRX_LOAD));

    // R8
    lock_never_long_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOCK) |-> (left_q <= RFC_LOAD));

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int unsigned TICK_CYCLES = 1040,
    parameter int unsigned MAX_OWED    = 8,
    parameter int unsigned URGENT_AT   = 7,
    parameter int unsigned TRFC_CYCLES = 10,
    parameter int unsigned TXS_CYCLES  = 200
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           banks_idle_i,
    input  logic                           sr_exit_i,
    input  logic                           ref_gnt_i,
    output logic                           ref_req_o,
    output logic                           pre_all_req_o,
    output logic                           busy_o,
    output logic                           urgent_o,
    output logic [$clog2(MAX_OWED+1)-1:0]  owed_o
);
    import rfsh_pkg::*;

    localparam int unsigned OW = $clog2(MAX_OWED + 1);

    logic          tick;
    logic          take;
    logic [OW-1:0] owed;
    logic          urgent;
    phase_e        phase;
    arb_ctl_t      ctl;

    rfsh_interval_timer #(
        .TICK_CYCLES (TICK_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    rfsh_owed_counter #(
        .MAX_OWED  (MAX_OWED),
        .URGENT_AT (URGENT_AT)
    ) u_owed (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .take_i   (take),
        .owed_o   (owed),
        .urgent_o (urgent)
    );

    rfsh_lockout #(
        .TRFC_CYCLES (TRFC_CYCLES),
        .TXS_CYCLES  (TXS_CYCLES)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .start_rfc_i (take),
        .start_srx_i (sr_exit_i),
        .phase_o     (phase)
    );

    always_comb begin
        logic ready;
        ready       = (phase == PH_READY) && !sr_exit_i;
        ctl.ref_req = ready && (owed != '0) && banks_idle_i;
        ctl.pre_all = ready && urgent && !banks_idle_i;
        ctl.busy    = (phase != PH_READY) || urgent;
    end

    assign take          = ctl.ref_req && ref_gnt_i;
    assign ref_req_o     = ctl.ref_req;
    assign pre_all_req_o = ctl.pre_all;
    assign busy_o        = ctl.busy;
    assign urgent_o      = urgent;
    assign owed_o        = owed;

    // R8
    grant_then_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && ref_gnt_i) |=> (busy_o && !ref_req_o));

    // R4
    pending_keeps_count_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_req_o && !ref_gnt_i && !tick) |=> (owed_o == $past(owed_o)));

    // R7
    one_request_kind_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ref_req_o, pre_all_req_o}));

    // R11
    urgent_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        urgent_o |-> busy_o);

endmodule

// File: tb/tb_refresh_sched.sv
module tb_refresh_sched;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 2;
    localparam int T          = 100;
    localparam int MAXO       = 8;
    localparam int URG        = 7;
    localparam int TRFC       = 10;
    localparam int TXS        = 40;
    localparam int WD_CYCLES  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       banks_idle_i = 1'b0;
    logic       sr_exit_i = 1'b0;
    logic       ref_gnt_i = 1'b0;
    logic       ref_req_o, pre_all_req_o, busy_o, urgent_o;
    logic [3:0] owed_o;

    int total = 0;
    int fails = 0;
    bit over_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    refresh_sched #(
        .TICK_CYCLES (T),
        .MAX_OWED    (MAXO),
        .URGENT_AT   (URG),
        .TRFC_CYCLES (TRFC),
        .TXS_CYCLES  (TXS)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .banks_idle_i  (banks_idle_i),
        .sr_exit_i     (sr_exit_i),
        .ref_gnt_i     (ref_gnt_i),
        .ref_req_o     (ref_req_o),
        .pre_all_req_o (pre_all_req_o),
        .busy_o        (busy_o),
        .urgent_o      (urgent_o),
        .owed_o        (owed_o)
    );

    always @(negedge clk) if (!rst && owed_o > MAXO) over_seen = 1'b1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        #(QTR);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; banks_idle_i = 1'b0; sr_exit_i = 1'b0; ref_gnt_i = 1'b0;
        cyc(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        settle();
        chk("R1 owed", int'(owed_o), 0);
        chk("R1 ref_req", int'(ref_req_o), 0);
        chk("R1 pre_all", int'(pre_all_req_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 urgent", int'(urgent_o), 0);
    endtask

    task automatic t_tick();
        do_reset();
        cyc(T - 1); settle();
        chk("R2 before first interval", int'(owed_o), 0);
        cyc(1); settle();
        chk("R2 first interval", int'(owed_o), 1);
        cyc(T); settle();
        chk("R2 second interval", int'(owed_o), 2);
    endtask

    task automatic t_urgent();
        do_reset();
        cyc(6 * T); settle();
        chk("R6 owed six", int'(owed_o), 6);
        chk("R6 not urgent below level", int'(urgent_o), 0);
        chk("R7 no precharge-all when not urgent", int'(pre_all_req_o), 0);
        chk("R11 not busy when not urgent", int'(busy_o), 0);
        chk("R4 no request with banks open", int'(ref_req_o), 0);
        cyc(T); settle();
        chk("R6 owed seven", int'(owed_o), 7);
        chk("R6 urgent at level", int'(urgent_o), 1);
        chk("R7 precharge-all when urgent", int'(pre_all_req_o), 1);
        chk("R11 busy when urgent", int'(busy_o), 1);
        banks_idle_i = 1'b1; settle();
        chk("R7 precharge-all drops once idle", int'(pre_all_req_o), 0);
        chk("R4 request once idle", int'(ref_req_o), 1);
        @(negedge clk);
        ref_gnt_i = 1'b1;
        cyc(1); settle();
        chk("R5 grant lowers count", int'(owed_o), 6);
        chk("R6 urgency clears", int'(urgent_o), 0);
        ref_gnt_i = 1'b0; banks_idle_i = 1'b0;
    endtask

    task automatic t_hold();
        int first_g = -1;
        int second_g = -1;
        int ngr = 0;
        int busy_cnt = 0;
        int req_in_busy = 0;
        do_reset();
        cyc(2 * T); settle();
        chk("R2 two owed", int'(owed_o), 2);
        chk("R4 no opportunistic request while banks open", int'(ref_req_o), 0);
        banks_idle_i = 1'b1; settle();
        chk("R4 request with banks idle", int'(ref_req_o), 1);
        cyc(3); settle();
        chk("R4 request held without grant", int'(ref_req_o), 1);
        chk("R4 count kept without grant", int'(owed_o), 2);
        @(negedge clk);
        ref_gnt_i = 1'b1;
        for (int i = 0; i < 2 * TRFC + 4; i++) begin
            settle();
            if (ref_req_o && ref_gnt_i) begin
                ngr++;
                if (first_g < 0) first_g = i; else second_g = i;
            end
            if (busy_o) begin
                busy_cnt++;
                if (ref_req_o) req_in_busy++;
            end
            @(negedge clk);
        end
        chk("R5 two grants", ngr, 2);
        chk("R8 grant spacing", second_g - first_g, TRFC + 1);
        chk("R8 busy cycles", busy_cnt, 2 * TRFC);
        chk("R8 no request while locked", req_in_busy, 0);
        chk("R5 count drained", int'(owed_o), 0);
        ref_gnt_i = 1'b0; banks_idle_i = 1'b0;
    endtask

    task automatic t_burst();
        int last_g = -1;
        int ngr = 0;
        int bad_gap = 0;
        do_reset();
        cyc(8 * T); settle();
        chk("R3 full backlog", int'(owed_o), MAXO);
        cyc(T); settle();
        chk("R3 saturates at limit", int'(owed_o), MAXO);
        @(negedge clk);
        banks_idle_i = 1'b1; ref_gnt_i = 1'b1;
        for (int i = 0; i < 90; i++) begin
            settle();
            if (ref_req_o && ref_gnt_i) begin
                ngr++;
                if (last_g >= 0 && (i - last_g) != TRFC + 1) bad_gap++;
                last_g = i;
            end
            @(negedge clk);
        end
        chk("R9 burst grant count", ngr, MAXO);
        chk("R9 burst gaps", bad_gap, 0);
        settle();
        chk("R9 backlog empty", int'(owed_o), 0);
        chk("R3 never above limit", int'(over_seen), 0);
        ref_gnt_i = 1'b0; banks_idle_i = 1'b0;
    endtask

    task automatic t_srx();
        int busy_cnt = 0;
        int req_seen = 0;
        int last_busy = 1;
        int last_req = 0;
        do_reset();
        cyc(T); settle();
        chk("R2 one owed", int'(owed_o), 1);
        @(negedge clk);
        banks_idle_i = 1'b1; settle();
        chk("R4 request before exit", int'(ref_req_o), 1);
        @(negedge clk);
        sr_exit_i = 1'b1; settle();
        chk("R10 request masked during exit pulse", int'(ref_req_o), 0);
        @(negedge clk);
        sr_exit_i = 1'b0;
        for (int i = 1; i <= TXS + 1; i++) begin
            settle();
            if (i <= TXS) begin
                if (busy_o) busy_cnt++;
                if (ref_req_o) req_seen++;
            end else begin
                last_busy = int'(busy_o);
                last_req = int'(ref_req_o);
            end
            @(negedge clk);
        end
        chk("R10 busy through exit window", busy_cnt, TXS);
        chk("R10 no request in exit window", req_seen, 0);
        chk("R10 busy ends after window", last_busy, 0);
        chk("R10 request resumes after window", last_req, 1);
        chk("R10 count kept", int'(owed_o), 1);
        banks_idle_i = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_tick();
        t_urgent();
        t_hold();
        t_burst();
        t_srx();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule